// File: doc/BRIEF.md
# Wide-to-Narrow Bus Request Splitter

The block accepts 128-bit memory requests over a valid/ready port. Each request carries one write-enable flag, a 16-byte-line address, 128 bits of write data and 16 byte enables. The block turns each request into zero, one or two 64-bit Wishbone classic-cycle master transactions. A 64-bit half is placed on the bus only when at least one of its eight byte enables is set. A request that needs only one half therefore costs one bus cycle. Only a request with enables in both halves costs two.

For reads, the block places each returned 64-bit word in its matching half of a 128-bit response. A half that was skipped reads as zero. Writes return a response as well, with all-zero data, so that every request is acknowledged upstream exactly once.

Back-pressure works as follows. `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. After that the block accepts nothing more until the upstream side takes the response, which happens on an edge where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the response is held unchanged.

Top module: `wbs_splitter`

## Requirements
- R1: `req_ready` is high only in the idle state. Once a request is accepted, `req_ready` stays low until the edge that hands over the response.
- R2: When only enables 7..0 are set, exactly one transaction is issued. Its `wb_adr` is {line, 1'b0, 3'b000}, meaning bit 3 is clear and bits 2..0 are zero, and `wb_sel` equals enables 7..0.
- R3: When only enables 15..8 are set, exactly one transaction is issued. Its `wb_adr` is {line, 1'b1, 3'b000} and `wb_sel` equals enables 15..8.
- R4: When both halves have enables, the lower half is issued first. The upper half starts in the cycle right after the cycle in which the lower half's ack is seen.
- R5: `wb_cyc` and `wb_stb` rise and fall together. While they are high without ack, `wb_adr`, `wb_sel`, `wb_we` and `wb_dat_o` hold steady.
- R6: `rsp_valid` rises in the cycle after the cycle in which the last needed ack is seen.
- R7: On reads, the word returned for the lower half fills response bits 63..0 and the word for the upper half fills bits 127..64. A skipped half reads as zero.
- R8: A request whose 16 enables are all zero issues no bus cycle. Its `rsp_valid` rises in the cycle after acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` does not change.
- R10: After reset, `req_ready` is high and `wb_cyc`, `wb_stb` and `rsp_valid` are low.
- R11: A write drives `wb_we` high and puts the matching 64 bits of write data on `wb_dat_o`: bits 63..0 for the lower half, bits 127..64 for the upper. A read drives `wb_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_line | input | LINE_AW (28) | 16-byte line address |
| req_wdata | input | 128 | Write data |
| req_be | input | 16 | Byte enables, bit i covers byte i |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Upstream takes the response |
| rsp_rdata | output | 128 | Assembled read data, zero for writes |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | LINE_AW+4 (32) | Byte address of the 64-bit word |
| wb_dat_o | output | 64 | Write data to the bus |
| wb_sel | output | 8 | Byte selects |
| wb_dat_i | input | 64 | Read data from the bus |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The assertions assume that the bus slave raises `wb_ack` only while `wb_stb` is high, and never two cycles in a row for the same strobe. They also assume that the upstream side holds its request fields stable only up to acceptance, because the block registers them there. The bench slave model acks one cycle after it sees a strobe, plus a chosen number of wait states, and drops ack for one cycle after each ack. Upstream stimulus changes only on falling edges and withdraws `req_valid` right after the accepting edge.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // Sequencer phases: waiting for a request, running bus cycles, holding the response
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUS  = 2'd1,
    PH_RSP  = 2'd2
  } wbs_phase_t;

  localparam int unsigned WBS_HALVES = 2;
endpackage

// File: rtl/wbs_half_plan.sv
module wbs_half_plan #(
  parameter int unsigned LANES = 8
) (
  input  logic [2*LANES-1:0] be,
  output logic               need_lo,
  output logic               need_hi,
  output logic               need_none
);
  import wbs_pkg::*;

  logic [WBS_HALVES-1:0] any_lane;

  // One OR tree per half of the byte-enable vector
  for (genvar h = 0; h < WBS_HALVES; h++) begin : g_half
    assign any_lane[h] = |be[h*LANES +: LANES];
  end

  assign need_lo   = any_lane[0];
  assign need_hi   = any_lane[1];
  assign need_none = ~|any_lane;
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic need_lo,
  input  logic need_hi,
  input  logic need_none,
  input  logic wb_ack,
  input  logic rsp_ready,
  output logic req_ready,
  output logic bus_act,
  output logic cur_hi,
  output logic rsp_valid,
  output logic fire,
  output logic take
);
  import wbs_pkg::*;

  wbs_phase_t phase_q, phase_d;
  logic       cur_hi_d;
  logic       hi_pend_q, hi_pend_d;

  assign req_ready = (phase_q == PH_IDLE);
  assign bus_act   = (phase_q == PH_BUS);
  assign rsp_valid = (phase_q == PH_RSP);
  assign fire      = req_valid && req_ready;
  assign take      = bus_act && wb_ack;

  always_comb begin
    phase_d   = phase_q;
    cur_hi_d  = cur_hi;
    hi_pend_d = hi_pend_q;
    unique case (phase_q)
      PH_IDLE: if (fire) begin
        hi_pend_d = need_hi;
        cur_hi_d  = ~need_lo;
        phase_d   = need_none ? PH_RSP : PH_BUS;
      end
      PH_BUS: if (wb_ack) begin
        if (!cur_hi && hi_pend_q) begin
          cur_hi_d = 1'b1;
        end else begin
          phase_d = PH_RSP;
        end
      end
      PH_RSP: if (rsp_ready) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cur_hi    <= 1'b0;
      hi_pend_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cur_hi    <= cur_hi_d;
      hi_pend_q <= hi_pend_d;
    end
  end

  // R4
  lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && wb_ack && !cur_hi && hi_pend_q) |=> (bus_act && cur_hi));

  // R8
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need_none) |=> (rsp_valid && !bus_act));

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready);

  // R6
  rsp_after_last_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_act && wb_ack && (cur_hi || !hi_pend_q)) |=> rsp_valid);
endmodule

// File: rtl/wbs_rdata_join.sv
module wbs_rdata_join #(
  parameter int unsigned BUS_DW = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                take,
  input  logic                take_hi,
  input  logic [BUS_DW-1:0]   dat_i,
  output logic [2*BUS_DW-1:0] data
);
  import wbs_pkg::*;

  // One register slot per half; a skipped half keeps its cleared value
  for (genvar h = 0; h < WBS_HALVES; h++) begin : g_slot
    logic [BUS_DW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        slot_q <= '0;
      end else if (take && (take_hi == h[0])) begin
        slot_q <= dat_i;
      end
    end
    assign data[h*BUS_DW +: BUS_DW] = slot_q;
  end
endmodule

// File: rtl/wbs_splitter.sv
module wbs_splitter #(
  parameter int unsigned LINE_AW = 28,
  parameter int unsigned BUS_DW  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [LINE_AW-1:0]        req_line,
  input  logic [2*BUS_DW-1:0]       req_wdata,
  input  logic [2*BUS_DW/8-1:0]     req_be,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [2*BUS_DW-1:0]       rsp_rdata,
  output logic                      wb_cyc,
  output logic                      wb_stb,
  output logic                      wb_we,
  output logic [LINE_AW+$clog2(BUS_DW/8):0] wb_adr,
  output logic [BUS_DW-1:0]         wb_dat_o,
  output logic [BUS_DW/8-1:0]       wb_sel,
  input  logic [BUS_DW-1:0]         wb_dat_i,
  input  logic                      wb_ack
);
  localparam int unsigned LANES = BUS_DW / 8;
  localparam int unsigned OFS   = $clog2(LANES);

  logic need_lo, need_hi, need_none;
  logic bus_act, cur_hi, fire, take;

  logic                  we_q;
  logic [LINE_AW-1:0]    line_q;
  logic [2*BUS_DW-1:0]   wdata_q;
  logic [2*LANES-1:0]    be_q;

  wbs_half_plan #(.LANES(LANES)) i_plan (
    .be        (req_be),
    .need_lo   (need_lo),
    .need_hi   (need_hi),
    .need_none (need_none)
  );

  wbs_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .need_lo   (need_lo),
    .need_hi   (need_hi),
    .need_none (need_none),
    .wb_ack    (wb_ack),
    .rsp_ready (rsp_ready),
    .req_ready (req_ready),
    .bus_act   (bus_act),
    .cur_hi    (cur_hi),
    .rsp_valid (rsp_valid),
    .fire      (fire),
    .take      (take)
  );

  // Request fields are captured once, at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      line_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (fire) begin
      we_q    <= req_we;
      line_q  <= req_line;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  wbs_rdata_join #(.BUS_DW(BUS_DW)) i_join (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fire),
    .take    (take && !we_q),
    .take_hi (cur_hi),
    .dat_i   (wb_dat_i),
    .data    (rsp_rdata)
  );

  assign wb_cyc   = bus_act;
  assign wb_stb   = bus_act;
  assign wb_we    = we_q;
  assign wb_adr   = {line_q, cur_hi, {OFS{1'b0}}};
  assign wb_sel   = cur_hi ? be_q[2*LANES-1:LANES] : be_q[LANES-1:0];
  assign wb_dat_o = cur_hi ? wdata_q[2*BUS_DW-1:BUS_DW] : wdata_q[BUS_DW-1:0];

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb && !wb_ack) |=> (wb_stb && wb_cyc && $stable(wb_adr) && $stable(wb_sel)
                              && $stable(wb_we) && $stable(wb_dat_o)));

  // R5
  cyc_stb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc == wb_stb);

  // R2
  sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> (wb_sel != '0));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: tb/test_wbs_splitter.sv
module test_wbs_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_AW = 28;
  localparam int AW = LINE_AW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [LINE_AW-1:0] req_line = '0;
  logic [127:0]  req_wdata = '0;
  logic [15:0]   req_be = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [127:0]  rsp_rdata;
  logic          wb_cyc, wb_stb, wb_we;
  logic [AW-1:0] wb_adr;
  logic [63:0]   wb_dat_o;
  logic [7:0]    wb_sel;
  logic [63:0]   wb_dat_i;
  logic          wb_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  wbs_splitter #(.LINE_AW(LINE_AW), .BUS_DW(64)) i_wbs_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_line(req_line), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] word_at(input logic [AW-1:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  assign wb_dat_i = word_at(wb_adr);

  // Slave model with a transaction log
  int cnt = 0;
  int wait_states = 0;
  int log_n = 0;
  int stab_err = 0;
  bit in_t = 0;
  int wcnt = 0;
  logic [AW-1:0] lg_adr [64];
  logic [7:0]    lg_sel [64];
  logic          lg_we  [64];
  logic [63:0]   lg_dat [64];
  int            lg_start [64];

  always @(posedge clk) begin
    int remain;
    cnt <= cnt + 1;
    wb_ack <= 1'b0;
    if (rst_n && wb_stb && !wb_ack) begin
      if (!in_t) begin
        lg_adr[log_n % 64]   <= wb_adr;
        lg_sel[log_n % 64]   <= wb_sel;
        lg_we[log_n % 64]    <= wb_we;
        lg_dat[log_n % 64]   <= wb_dat_o;
        lg_start[log_n % 64] <= cnt;
        log_n <= log_n + 1;
        remain = wait_states;
      end else begin
        remain = wcnt;
        if (wb_adr !== lg_adr[(log_n-1) % 64] || wb_sel !== lg_sel[(log_n-1) % 64])
          stab_err <= stab_err + 1;
      end
      if (remain == 0) begin
        wb_ack <= 1'b1;
        in_t <= 1'b0;
      end else begin
        in_t <= 1'b1;
        wcnt <= remain - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request; returns read data, cycle of first rsp_valid and hold status
  task automatic do_req(input logic we, input logic [LINE_AW-1:0] line,
                        input logic [127:0] wd, input logic [15:0] be,
                        input int waits, input int hold,
                        output logic [127:0] rd, output int acc, output int rsp_at,
                        output int hold_bad);
    int guard;
    wait_states = waits;
    hold_bad = 0;
    @(negedge clk);
    req_we = we; req_line = line; req_wdata = wd; req_be = be; req_valid = 1'b1;
    acc = cnt;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    rsp_at = cnt;
    rd = rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || req_ready || rsp_rdata !== rd) hold_bad++;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R10
    check(req_ready && !wb_cyc && !wb_stb && !rsp_valid, "R10",
          {req_ready, wb_cyc, wb_stb, rsp_valid}, 4'b1000);
  endtask

  task automatic t_lower_write();
    logic [127:0] rd; int acc, rs, hb, b;
    logic [127:0] wd = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    b = log_n;
    do_req(1'b1, 28'h0ABCDE1, wd, 16'h00F3, 0, 0, rd, acc, rs, hb);
    // R2
    check(log_n - b == 1, "R2 count", log_n - b, 1);
    check(lg_adr[b] == {28'h0ABCDE1, 4'h0}, "R2 adr", lg_adr[b], {28'h0ABCDE1, 4'h0});
    check(lg_sel[b] == 8'hF3, "R2 sel", lg_sel[b], 8'hF3);
    // R11
    check(lg_we[b] && lg_dat[b] == wd[63:0], "R11 lo data", lg_dat[b], wd[63:0]);
    check(rd == '0, "R7 write rsp zero", rd, 0);
  endtask

  task automatic t_upper_write();
    logic [127:0] rd; int acc, rs, hb, b;
    logic [127:0] wd = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98;
    b = log_n;
    do_req(1'b1, 28'h0000010, wd, 16'h8100, 0, 0, rd, acc, rs, hb);
    // R3
    check(log_n - b == 1, "R3 count", log_n - b, 1);
    check(lg_adr[b] == {28'h0000010, 4'h8}, "R3 adr", lg_adr[b], {28'h0000010, 4'h8});
    check(lg_sel[b] == 8'h81, "R3 sel", lg_sel[b], 8'h81);
    // R11
    check(lg_we[b] && lg_dat[b] == wd[127:64], "R11 hi data", lg_dat[b], wd[127:64]);
  endtask

  task automatic t_both_read();
    logic [127:0] rd, ex; int acc, rs, hb, b;
    b = log_n;
    do_req(1'b0, 28'h1234567, '0, 16'h0180, 0, 0, rd, acc, rs, hb);
    // R4
    check(log_n - b == 2, "R4 count", log_n - b, 2);
    check(!lg_adr[b][3] && lg_adr[b+1][3], "R4 order", {lg_adr[b], lg_adr[b+1]}, 0);
    check(lg_start[b+1] - lg_start[b] == 2, "R4 gap", lg_start[b+1] - lg_start[b], 2);
    check(lg_sel[b] == 8'h80 && lg_sel[b+1] == 8'h01, "R4 sel",
          {lg_sel[b], lg_sel[b+1]}, 16'h8001);
    // R11
    check(!lg_we[b] && !lg_we[b+1], "R11 read we", {lg_we[b], lg_we[b+1]}, 0);
    // R7
    ex = {word_at({28'h1234567, 4'h8}), word_at({28'h1234567, 4'h0})};
    check(rd == ex, "R7 both halves", rd, ex);
  endtask

  task automatic t_upper_read();
    logic [127:0] rd, ex; int acc, rs, hb, b;
    b = log_n;
    do_req(1'b0, 28'h0FFFFFF, '0, 16'hFF00, 0, 0, rd, acc, rs, hb);
    ex = {word_at({28'h0FFFFFF, 4'h8}), 64'h0};
    // R7
    check(rd == ex, "R7 skipped low zero", rd, ex);
    check(log_n - b == 1, "R3 read count", log_n - b, 1);
  endtask

  task automatic t_wait_states();
    logic [127:0] rd, ex; int acc, rs, hb, b;
    b = log_n;
    stab_err = 0;
    do_req(1'b0, 28'h0000777, '0, 16'h4002, 3, 0, rd, acc, rs, hb);
    // R5
    check(stab_err == 0, "R5 stable under waits", stab_err, 0);
    check(lg_start[b+1] - lg_start[b] == 5, "R4 gap with waits",
          lg_start[b+1] - lg_start[b], 5);
    // R6
    check(rs == lg_start[b+1] + 5, "R6 rsp timing", rs, lg_start[b+1] + 5);
    ex = {word_at({28'h0000777, 4'h8}), word_at({28'h0000777, 4'h0})};
    check(rd == ex, "R7 with waits", rd, ex);
  endtask

  task automatic t_zero_be();
    logic [127:0] rd; int acc, rs, hb, b;
    b = log_n;
    do_req(1'b0, 28'h0000042, '0, 16'h0000, 0, 0, rd, acc, rs, hb);
    // R8
    check(log_n == b, "R8 no bus cycle", log_n - b, 0);
    check(rs == acc + 1, "R8 rsp timing", rs, acc + 1);
    check(rd == '0, "R8 zero data", rd, 0);
  endtask

  task automatic t_backpressure();
    logic [127:0] rd, ex; int acc, rs, hb, b;
    b = log_n;
    do_req(1'b0, 28'h0000100, '0, 16'h000F, 1, 4, rd, acc, rs, hb);
    ex = {64'h0, word_at({28'h0000100, 4'h0})};
    // R9, R1
    check(hb == 0, "R9 R1 held response", hb, 0);
    check(rd == ex, "R9 data", rd, ex);
    @(negedge clk);
    // R1
    check(req_ready && !rsp_valid, "R1 idle after handover", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_lower_write();
    t_upper_write();
    t_both_read();
    t_upper_read();
    t_wait_states();
    t_zero_be();
    t_backpressure();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule